// File: doc/BRIEF.md
# External and Pin-Change Interrupt Front End

This block collects interrupt events for a small 8-bit microcontroller and turns them into request lines for a vector arbiter. It has two kinds of input. Eight dedicated external lines each have their own sense mode, enable bit and flag. Thirteen pin-change inputs are split into a group of eight and a group of five. Each group has per-pin masks and one group flag, and each group shares a single vector. Every input passes through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the one from the cycle before.

Software reaches the enables, flags and masks through a byte-wide register port. Reads are combinational from `reg_addr`. A write takes effect on the clock edge where `reg_wr` is high. Flags are cleared by writing a 1 to their bit, or by an acknowledge pulse from the arbiter when the vector is taken. Every request is further gated by a global interrupt enable input and comes from a register.

Register map (`reg_addr`): 0 external enables, 1 external flags, 2 mask of group 0 (`pc_pin[7:0]`), 3 mask of group 1 (`pc_pin[12:8]` in bits 4:0), 4 group enables (bits 1:0), 5 group flags (bits 1:0). Addresses 6 and 7 read 0.

Top module: `irq_front`

## Requirements
- R1: After reset every register reads 0 and all request outputs are 0.
- R2: An edge-mode external request `ext_irq[i]` is 1 only when flag i, enable bit i and `gie` were all 1 on the previous clock edge. It drops one cycle after `gie` falls.
- R3: `ext_sense[2i+1:2i]` selects the mode of line i: 2'b11 is rising edge, 2'b10 is falling edge, and 2'b00 or 2'b01 is low level. A qualifying edge sets flag i whether or not line i is enabled. An edge in the other direction does nothing.
- R4: Writing address 1 clears every flag bit written as 1. Bits written as 0 keep their value.
- R5: A pulse on `ext_ack[i]` clears flag i on the next edge, and `ext_irq[i]` is 0 from that same edge on.
- R6: If a new qualifying event reaches a flag in the same cycle as an acknowledge or a write-one clear, the flag stays set.
- R7: In level mode, flag i always reads 0, and `ext_irq[i]` is 1 while the synchronized pin is low, line i is enabled and `gie` is 1.
- R8: Any transition, in either direction, on a pin-change input that is unmasked (mask bit 1) and in a group whose enable bit is 1 sets that group's flag. A masked pin or a disabled group sets nothing.
- R9: `pc_irq[g]` is the registered AND of group flag g, group enable g and `gie`. The group flag clears on `pc_ack[g]` or on writing 1 to bit g of address 5.
- R10: Bits 7:2 of addresses 4 and 5 and bits 7:5 of address 3 always read 0. Writes to them are ignored.
- R11: A pin change driven just after edge 0 shows in the flag after the third rising edge and in the request after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 8 | External interrupt inputs |
| ext_sense | input | 16 | Two sense-mode bits per external line |
| pc_pin | input | 13 | Pin-change inputs; group 0 = [7:0], group 1 = [12:8] |
| gie | input | 1 | Global interrupt enable |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_ack | input | 8 | Vector-taken pulses, one per external line |
| pc_ack | input | 2 | Vector-taken pulses, one per pin-change group |
| ext_irq | output | 8 | External interrupt requests |
| pc_irq | output | 2 | Pin-change group requests |

## Verification
A wrong edge sample or a stuck synchronizer stage shows up in the flag registers three edges after the pin moves, and in the request one edge after that. The bench samples exactly at those points. Faulty clear logic leaves a flag set where writing 0 should leave it alone or writing 1 should clear it, and the register read that follows shows it. A lost event at a clear-event collision shows up as a zero flag. Masking or group-enable faults show up as a group flag that is wrong within four cycles of a toggle, across a long run of random pin patterns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int EXT_N  = 8;
  localparam int PC0_W  = 8;
  localparam int PC1_W  = 5;
  localparam int PC_N   = PC0_W + PC1_W;
  localparam int GRP_N  = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_EXT_EN   = 3'd0;
  localparam logic [ADDR_W-1:0] A_EXT_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK0    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK1    = 3'd3;
  localparam logic [ADDR_W-1:0] A_GRP_EN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_GRP_FLAG = 3'd5;

  typedef enum logic [1:0] {
    SENSE_LOW0 = 2'b00,
    SENSE_LOW1 = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] p
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign s = sync_q;
  assign p = prev_q;
endmodule

// File: rtl/irq_ext_unit.sv
module irq_ext_unit #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   s,
  input  logic [N-1:0]   p,
  input  logic [2*N-1:0] sense,
  input  logic [N-1:0]   en,
  input  logic           gie,
  input  logic [N-1:0]   clr,
  input  logic [N-1:0]   ack,
  output logic [N-1:0]   flag,
  output logic [N-1:0]   irq
);
  logic [N-1:0] flag_q, flag_d, irq_q, irq_d, level, set;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall;
    assign rise     = s[i] & ~p[i];
    assign fall     = ~s[i] & p[i];
    assign level[i] = ~sense[2*i+1];
    assign set[i]   = ~level[i] & (sense[2*i] ? rise : fall);

    always_comb begin
      flag_d[i] = flag_q[i];
      if (level[i])               flag_d[i] = 1'b0;
      else if (set[i])            flag_d[i] = 1'b1;
      else if (clr[i] || ack[i])  flag_d[i] = 1'b0;
      if (level[i]) irq_d[i] = en[i] & gie & ~s[i];
      else          irq_d[i] = en[i] & gie & flag_q[i] & ~(clr[i] | ack[i]);
    end

    assert_level_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      level[i] |=> !flag_q[i]);
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set[i]) |=> !flag_q[i]);
    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !level[i]) |=> !irq_q[i]);
    assert_gie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[i] |-> $past(gie));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= '0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/irq_pc_unit.sv
module irq_pc_unit #(
  parameter int G0_W = 8,
  parameter int G1_W = 5,
  localparam int N   = G0_W + G1_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] s,
  input  logic [N-1:0] p,
  input  logic [N-1:0] mask,
  input  logic [1:0]   gen,
  input  logic         gie,
  input  logic [1:0]   clr,
  input  logic [1:0]   ack,
  output logic [1:0]   flag,
  output logic [1:0]   irq
);
  logic [N-1:0] chg;
  logic [1:0]   hit, set, flag_q, flag_d, irq_q, irq_d;

  assign chg    = (s ^ p) & mask;
  assign hit[0] = |chg[G0_W-1:0];
  assign hit[1] = |chg[N-1:G0_W];
  assign set    = hit & gen;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    always_comb begin
      flag_d[g] = flag_q[g];
      if (set[g])                 flag_d[g] = 1'b1;
      else if (clr[g] || ack[g])  flag_d[g] = 1'b0;
      irq_d[g] = gen[g] & gie & flag_q[g] & ~(clr[g] | ack[g]);
    end

    assert_pc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> flag_q[g]);
    assert_pc_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[g] && !set[g]) |=> !flag_q[g]);
    assert_pc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> $past(gie && gen[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= '0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  ext_pin,
  input  logic [2*EXT_N-1:0] ext_sense,
  input  logic [PC_N-1:0]   pc_pin,
  input  logic              gie,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EXT_N-1:0]  ext_ack,
  input  logic [GRP_N-1:0]  pc_ack,
  output logic [EXT_N-1:0]  ext_irq,
  output logic [GRP_N-1:0]  pc_irq
);
  logic [EXT_N-1:0] ext_s, ext_p, ext_flag, ext_clr, ext_en_q, ext_en_d;
  logic [PC_N-1:0]  pc_s, pc_p, mask_q, mask_d;
  logic [GRP_N-1:0] gen_q, gen_d, grp_flag, grp_clr;
  logic             wr_en, wr_m0, wr_m1, wr_gen;

  irq_sync #(.W(EXT_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .s(ext_s), .p(ext_p));
  irq_sync #(.W(PC_N)) u_pc_sync (
    .clk(clk), .rst_n(rst_n), .d(pc_pin), .s(pc_s), .p(pc_p));

  assign wr_en   = reg_wr && (reg_addr == A_EXT_EN);
  assign wr_m0   = reg_wr && (reg_addr == A_MASK0);
  assign wr_m1   = reg_wr && (reg_addr == A_MASK1);
  assign wr_gen  = reg_wr && (reg_addr == A_GRP_EN);
  assign ext_clr = (reg_wr && reg_addr == A_EXT_FLAG) ? reg_wdata : '0;
  assign grp_clr = (reg_wr && reg_addr == A_GRP_FLAG) ? reg_wdata[GRP_N-1:0] : '0;

  always_comb begin
    ext_en_d = ext_en_q;
    mask_d   = mask_q;
    gen_d    = gen_q;
    if (wr_en)  ext_en_d = reg_wdata;
    if (wr_m0)  mask_d[PC0_W-1:0] = reg_wdata[PC0_W-1:0];
    if (wr_m1)  mask_d[PC_N-1:PC0_W] = reg_wdata[PC1_W-1:0];
    if (wr_gen) gen_d = reg_wdata[GRP_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en_q <= '0;
      mask_q   <= '0;
      gen_q    <= '0;
    end else begin
      ext_en_q <= ext_en_d;
      mask_q   <= mask_d;
      gen_q    <= gen_d;
    end
  end

  irq_ext_unit #(.N(EXT_N)) u_ext (
    .clk(clk), .rst_n(rst_n), .s(ext_s), .p(ext_p), .sense(ext_sense),
    .en(ext_en_q), .gie(gie), .clr(ext_clr), .ack(ext_ack),
    .flag(ext_flag), .irq(ext_irq));

  irq_pc_unit #(.G0_W(PC0_W), .G1_W(PC1_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .s(pc_s), .p(pc_p), .mask(mask_q),
    .gen(gen_q), .gie(gie), .clr(grp_clr), .ack(pc_ack),
    .flag(grp_flag), .irq(pc_irq));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EXT_EN:   reg_rdata = ext_en_q;
      A_EXT_FLAG: reg_rdata = ext_flag;
      A_MASK0:    reg_rdata = mask_q[PC0_W-1:0];
      A_MASK1:    reg_rdata[PC1_W-1:0] = mask_q[PC_N-1:PC0_W];
      A_GRP_EN:   reg_rdata[GRP_N-1:0] = gen_q;
      A_GRP_FLAG: reg_rdata[GRP_N-1:0] = grp_flag;
      default:    reg_rdata = '0;
    endcase
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (ext_irq == '0 && pc_irq == '0));
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_GRP_EN || reg_addr == A_GRP_FLAG) |-> reg_rdata[7:2] == 6'd0);
endmodule

// File: tb/irq_front_bench.sv
module irq_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic        clk, rst_n, gie, reg_wr;
  logic [7:0]  ext_pin, reg_wdata, reg_rdata, ext_ack, ext_irq;
  logic [15:0] ext_sense;
  logic [12:0] pc_pin;
  logic [2:0]  reg_addr;
  logic [1:0]  pc_ack, pc_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_front u_irq_front (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_sense(ext_sense),
    .pc_pin(pc_pin), .gie(gie), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_ack(ext_ack),
    .pc_ack(pc_ack), .ext_irq(ext_irq), .pc_irq(pc_irq));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(1);
    reg_wr = 0;
  endtask

  function automatic logic [7:0] ext_events(input logic [7:0] o, input logic [7:0] n,
                                            input logic [15:0] sn);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (sn[2*i+1])
        r[i] = sn[2*i] ? (!o[i] && n[i]) : (o[i] && !n[i]);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, nv, wv, exp_ext;
    logic [12:0] npc;
    logic [1:0] exp_pc;
    int seed_v;
    seed_v = $urandom(SEED);
    rst_n = 0; gie = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ext_pin = 0; pc_pin = 0; ext_ack = 0; pc_ack = 0; ext_sense = 16'hFFFF;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg", d, 0);
    end
    chk("R1 irq", {ext_irq, pc_irq}, 0);

    // R11 / R2 latency on line 0 (rising)
    wr(0, 8'h01); gie = 1;
    ext_pin[0] = 1;
    tick(3);
    rd(1, d);
    chk("R11 flag after 3", d[0], 1);
    chk("R11 irq not yet", ext_irq[0], 0);
    tick(1);
    chk("R2 irq after 4", ext_irq[0], 1);
    gie = 0; tick(1);
    chk("R2 gie off", ext_irq[0], 0);
    rd(1, d); chk("R2 flag kept", d[0], 1);
    gie = 1; tick(1);
    chk("R2 gie on", ext_irq[0], 1);

    // R4 write zero no effect
    wr(1, 8'h00);
    rd(1, d); chk("R4 write0", d[0], 1);
    // R5 acknowledge
    ext_ack[0] = 1; tick(1); ext_ack[0] = 0;
    rd(1, d); chk("R5 ack flag", d[0], 0);
    chk("R5 ack irq", ext_irq[0], 0);
    // R3 wrong direction ignored
    ext_pin[0] = 0; tick(4);
    rd(1, d); chk("R3 fall ignored", d[0], 0);
    ext_pin[0] = 1; tick(4);
    rd(1, d); chk("R3 rise sets", d[0], 1);
    wr(1, 8'h01);
    rd(1, d); chk("R4 write1", d[0], 0);

    // R6 event wins over ack (line 1 falling)
    ext_sense[3:2] = 2'b10;
    ext_pin[1] = 1; tick(4);
    rd(1, d); chk("R3 rise ignored in fall", d[1], 0);
    ext_pin[1] = 0; tick(4);
    rd(1, d); chk("R3 fall sets", d[1], 1);
    ext_pin[1] = 1; tick(4);
    ext_pin[1] = 0; tick(2);
    ext_ack[1] = 1; tick(1); ext_ack[1] = 0;
    rd(1, d); chk("R6 event wins", d[1], 1);
    wr(1, 8'h02);

    // R7 level line 2
    ext_pin[2] = 1; ext_sense[5:4] = 2'b00; tick(4);
    wr(0, 8'h05); tick(2);
    chk("R7 high no irq", ext_irq[2], 0);
    ext_pin[2] = 0; tick(3);
    chk("R7 low irq", ext_irq[2], 1);
    rd(1, d); chk("R7 flag zero", d[2], 0);
    ext_pin[2] = 1; tick(3);
    chk("R7 release", ext_irq[2], 0);
    wr(0, 8'h00);

    // R8 / R9 pin change
    wr(2, 8'h08); wr(4, 8'h01);
    pc_pin[3] = 1; tick(4);
    rd(5, d); chk("R8 rise sets g0", d, 8'h01);
    chk("R9 irq g0", pc_irq[0], 1);
    pc_ack[0] = 1; tick(1); pc_ack[0] = 0;
    rd(5, d); chk("R9 ack g0", d, 0);
    chk("R9 ack irq g0", pc_irq[0], 0);
    pc_pin[4] = 1; tick(4);
    rd(5, d); chk("R8 masked", d, 0);
    pc_pin[3] = 0; tick(4);
    rd(5, d); chk("R8 fall sets g0", d, 8'h01);
    wr(5, 8'h01);
    rd(5, d); chk("R9 w1c g0", d, 0);
    wr(3, 8'h10);
    pc_pin[12] = 1; tick(4);
    rd(5, d); chk("R8 group off", d, 0);
    wr(4, 8'h03);
    pc_pin[12] = 0; tick(4);
    rd(5, d); chk("R8 g1 sets", d, 8'h02);
    chk("R9 irq g1", pc_irq[1], 1);
    gie = 0; tick(1);
    chk("R9 gie off g1", pc_irq[1], 0);
    gie = 1; wr(5, 8'h02);

    // R10 read-only upper bits
    wr(4, 8'hFF); rd(4, d); chk("R10 gen upper", d, 8'h03);
    wr(3, 8'hFF); rd(3, d); chk("R10 mask1 upper", d, 8'h1F);
    wr(5, 8'hFC); rd(5, d); chk("R10 flag upper", d, 0);
    rd(6, d); chk("R10 unused addr", d, 0);

    // R3 / R8 random patterns
    wr(2, 8'hFF);
    for (int i = 0; i < 8; i++) ext_sense[2*i +: 2] = {1'b1, 1'($urandom)};
    tick(4);
    wr(1, 8'hFF); wr(5, 8'h03);
    exp_ext = 0; exp_pc = 0;
    for (int it = 0; it < 60; it++) begin
      nv = 8'($urandom); npc = 13'($urandom);
      exp_ext |= ext_events(ext_pin, nv, ext_sense);
      if (npc[7:0] != pc_pin[7:0])   exp_pc[0] = 1;
      if (npc[12:8] != pc_pin[12:8]) exp_pc[1] = 1;
      ext_pin = nv; pc_pin = npc;
      tick(4);
      rd(1, d); chk("R3 random ext flags", d, exp_ext);
      rd(5, d); chk("R8 random group flags", d, {6'd0, exp_pc});
      if (it % 3 == 2) begin
        wv = 8'($urandom);
        wr(1, wv); exp_ext &= ~wv;
        wr(5, wv); exp_pc &= ~wv[1:0];
        rd(1, d); chk("R4 random clear", d, exp_ext);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule